// File: doc/BRIEF.md
# Two-Level Vector Register File

This block holds the vector registers of one SIMD lane group in two tiers. A small near tier sits next to the execution units. It serves two operand read ports and one result write port, and every read is combinational. A larger far tier, five times the size of the near tier by default, has no path to the execution units. Memory-load return data lands only in the far tier, so a register that is waiting on a load does not hold a near slot. Values cross between the tiers only when the instruction stream issues an explicit move command.

A move names a source index, a destination index and a direction. The block sequences one move at a time. Every move spends a latency cycle on the far side and then lands in the cycle after that. A far-to-near move reads the far tier with a one-cycle registered read and writes the near tier when that data arrives. A near-to-far move captures the near source when the command is accepted and writes the far tier two edges later. The far tier has a single write port, which the load return and the move sequencer share. The load always has priority, and a blocked move waits.

An operand read that names the destination of an in-flight far-to-near move raises a stall, so stale data is never consumed. Both tiers power up cleared.

Top module: `vreg_two_level`

## Requirements
- R1: After reset, every near register and every far register reads as zero, `mv_ready` is 1, and `mv_done` and `rd_stall` are 0.
- R2: A result write with `wr_en`=1 updates near register `wr_idx` at the clock edge. The new value appears combinationally on `rd_a_data` and `rd_b_data` from the next cycle whenever the index selects that register.
- R3: A move with `mv_dir`=1 (far to near) is accepted at an edge k while `mv_ready`=1. The far source index is the whole `mv_src`. The near destination is the low log2(NEAR_REGS) bits of `mv_dst`. Far register `mv_src` is sampled at edge k+1 and written to the near destination at edge k+2. `mv_done` is high for exactly the one cycle after edge k+2.
- R4: A move with `mv_dir`=0 (near to far) captures near register `mv_src` (low log2(NEAR_REGS) bits) at the accepting edge k. It writes that value to far register `mv_dst` at edge k+2 unless that edge is blocked (R6). `mv_done` pulses in the cycle after the write. The near source keeps its value.
- R5: A load return with `ld_en`=1 writes far register `ld_idx` and never changes any near register.
- R6: When a load return and a near-to-far move both write the far tier in the same cycle, the load is written and the move write is held until the first cycle without `ld_en`. `mv_done` is delayed by the same number of cycles, and the moved value ends up in the far register.
- R7: `rd_stall` is 1 exactly when `rd_en`=1, a far-to-near move is accepted but has not yet landed, and either `rd_a_idx` or `rd_b_idx` equals its near destination.
- R8: `mv_ready` is 0 from the edge that accepts a move until the move has landed. A command presented while `mv_ready`=0 is ignored.
- R9: When a result write and a landing far-to-near move target the same near register at the same edge, the result write's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Operand read request (qualifies stall) |
| rd_a_idx | input | log2(NEAR_REGS) | Operand port A near index |
| rd_b_idx | input | log2(NEAR_REGS) | Operand port B near index |
| rd_a_data | output | LANES*LANE_W | Operand port A data |
| rd_b_data | output | LANES*LANE_W | Operand port B data |
| rd_stall | output | 1 | Read hits pending far-to-near destination |
| wr_en | input | 1 | Result write enable |
| wr_idx | input | log2(NEAR_REGS) | Result write near index |
| wr_data | input | LANES*LANE_W | Result write data |
| mv_valid | input | 1 | Move command present |
| mv_dir | input | 1 | 1 = far to near, 0 = near to far |
| mv_src | input | log2(FAR_REGS) | Move source index |
| mv_dst | input | log2(FAR_REGS) | Move destination index |
| mv_ready | output | 1 | Sequencer idle, command accepted |
| mv_done | output | 1 | One-cycle pulse after the move write lands |
| ld_en | input | 1 | Load return write enable |
| ld_idx | input | log2(FAR_REGS) | Load return far index |
| ld_data | input | LANES*LANE_W | Load return data |

## Verification
The hardest case to reach is the held near-to-far move. The load port has to stay busy exactly across the move's landing cycle, and the far value that results is only visible after a second move brings it back into the near tier. The bench issues that move, then holds `ld_en` on the same far register for three cycles starting in the cycle after acceptance. It checks that `mv_done` has not appeared by the usual cycle and appears two cycles later. It then moves the far register back to a near register and reads it. A landing move that coincides with a result write to the same register is reached the same way, by timing the write to the landing cycle. A long random phase then mixes all four ports against a behavioural model that is compared on every cycle.

// File: rtl/vrf2_pkg.sv
package vrf2_pkg;

    // Direction of a tier-to-tier move.
    typedef enum logic {
        MV_TO_FAR  = 1'b0,
        MV_TO_NEAR = 1'b1
    } mv_dir_e;

    // Move sequencer phases: idle, far-latency cycle, landing cycle.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_LAND = 2'd2
    } seq_state_e;

    // True when either operand index hits a given register.
    function automatic logic idx_hit2(input logic [15:0] a, input logic [15:0] b,
                                      input logic [15:0] tgt);
        return (a == tgt) || (b == tgt);
    endfunction

endpackage

// File: rtl/vrf2_near_bank.sv
module vrf2_near_bank #(
    parameter int DW       = 64,
    parameter int DEPTH    = 16,
    parameter int RD_PORTS = 3,
    parameter int IW       = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [RD_PORTS-1:0][IW-1:0]  ridx,
    output logic [RD_PORTS-1:0][DW-1:0]  rdata,
    input  logic                         res_we,
    input  logic [IW-1:0]                res_idx,
    input  logic [DW-1:0]                res_data,
    input  logic                         mv_we,
    input  logic [IW-1:0]                mv_idx,
    input  logic [DW-1:0]                mv_data
);
    logic [DW-1:0] mem [DEPTH];

    // Combinational read ports, one per operand/sequencer consumer.
    for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
        assign rdata[g] = mem[ridx[g]];
    end

    // Two write ports; the result port is applied last and so wins a tie.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (mv_we)  mem[mv_idx]  <= mv_data;
            if (res_we) mem[res_idx] <= res_data;
        end
    end
endmodule

// File: rtl/vrf2_far_bank.sv
module vrf2_far_bank #(
    parameter int DW    = 64,
    parameter int DEPTH = 80,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          re,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata
);
    localparam logic [IW-1:0] TOP_IDX = IW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];

    // Registered read: data leaves the far tier one edge after the request.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (re) rdata <= (ridx <= TOP_IDX) ? mem[ridx] : '0;
            if (we && (widx <= TOP_IDX)) mem[widx] <= wdata;
        end
    end
endmodule

// File: rtl/vrf2_move_seq.sv
module vrf2_move_seq
    import vrf2_pkg::*;
#(
    parameter int DW  = 64,
    parameter int NIW = 4,
    parameter int FIW = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_valid,
    input  logic           cmd_dir,
    input  logic [FIW-1:0] cmd_src,
    input  logic [FIW-1:0] cmd_dst,
    input  logic           ld_busy,
    input  logic [DW-1:0]  near_src_data,
    input  logic [DW-1:0]  far_rd_data,
    output logic           cmd_ready,
    output logic           cmd_done,
    output logic           far_re,
    output logic [FIW-1:0] far_ridx,
    output logic           far_we,
    output logic [FIW-1:0] far_widx,
    output logic [DW-1:0]  far_wdata,
    output logic           near_we,
    output logic [NIW-1:0] near_widx,
    output logic [DW-1:0]  near_wdata,
    output logic           pend_near,
    output logic [NIW-1:0] pend_idx
);
    typedef struct packed {
        mv_dir_e        dir;
        logic [FIW-1:0] src;
        logic [FIW-1:0] dst;
    } cmd_t;

    seq_state_e    st_q;
    cmd_t          cmd_q;
    logic [DW-1:0] hold_q;
    logic          done_q;
    logic          landing;

    // A far-bound move may not land while the load return owns the far port.
    assign landing = (st_q == SEQ_LAND) &&
                     ((cmd_q.dir == MV_TO_NEAR) || !ld_busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            cmd_q  <= '0;
            hold_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= landing;
            unique case (st_q)
                SEQ_IDLE: if (cmd_valid) begin
                    cmd_q  <= '{dir: mv_dir_e'(cmd_dir), src: cmd_src, dst: cmd_dst};
                    hold_q <= near_src_data;
                    st_q   <= SEQ_WAIT;
                end
                SEQ_WAIT: st_q <= SEQ_LAND;
                SEQ_LAND: if (landing) st_q <= SEQ_IDLE;
                default:  st_q <= SEQ_IDLE;
            endcase
        end
    end

    assign cmd_ready  = (st_q == SEQ_IDLE);
    assign cmd_done   = done_q;
    assign far_re     = (st_q == SEQ_WAIT) && (cmd_q.dir == MV_TO_NEAR);
    assign far_ridx   = cmd_q.src;
    assign far_we     = landing && (cmd_q.dir == MV_TO_FAR);
    assign far_widx   = cmd_q.dst;
    assign far_wdata  = hold_q;
    assign near_we    = landing && (cmd_q.dir == MV_TO_NEAR);
    assign near_widx  = cmd_q.dst[NIW-1:0];
    assign near_wdata = far_rd_data;
    assign pend_near  = (st_q != SEQ_IDLE) && (cmd_q.dir == MV_TO_NEAR);
    assign pend_idx   = cmd_q.dst[NIW-1:0];
endmodule

// File: rtl/vreg_two_level.sv
module vreg_two_level
    import vrf2_pkg::*;
#(
    parameter int LANE_W       = 32,
    parameter int LANES        = 2,
    parameter int NEAR_REGS    = 16,
    parameter int FAR_PER_NEAR = 5,
    localparam int DW          = LANE_W * LANES,
    localparam int FAR_REGS    = NEAR_REGS * FAR_PER_NEAR,
    localparam int NIW         = $clog2(NEAR_REGS),
    localparam int FIW         = $clog2(FAR_REGS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_en,
    input  logic [NIW-1:0] rd_a_idx,
    input  logic [NIW-1:0] rd_b_idx,
    output logic [DW-1:0]  rd_a_data,
    output logic [DW-1:0]  rd_b_data,
    output logic           rd_stall,
    input  logic           wr_en,
    input  logic [NIW-1:0] wr_idx,
    input  logic [DW-1:0]  wr_data,
    input  logic           mv_valid,
    input  logic           mv_dir,
    input  logic [FIW-1:0] mv_src,
    input  logic [FIW-1:0] mv_dst,
    output logic           mv_ready,
    output logic           mv_done,
    input  logic           ld_en,
    input  logic [FIW-1:0] ld_idx,
    input  logic [DW-1:0]  ld_data
);
    logic [2:0][NIW-1:0] near_ridx;
    logic [2:0][DW-1:0]  near_rdata;
    logic                mv_near_we;
    logic [NIW-1:0]      mv_near_idx;
    logic [DW-1:0]       mv_near_data;
    logic                far_re;
    logic [FIW-1:0]      far_ridx;
    logic [DW-1:0]       far_rdata;
    logic                mv_far_we;
    logic [FIW-1:0]      mv_far_idx;
    logic [DW-1:0]       mv_far_data;
    logic                pend_near;
    logic [NIW-1:0]      pend_idx;

    assign near_ridx = {mv_src[NIW-1:0], rd_b_idx, rd_a_idx};
    assign rd_a_data = near_rdata[0];
    assign rd_b_data = near_rdata[1];

    vrf2_near_bank #(.DW(DW), .DEPTH(NEAR_REGS), .RD_PORTS(3)) u_near (
        .clk      (clk),
        .rst      (rst),
        .ridx     (near_ridx),
        .rdata    (near_rdata),
        .res_we   (wr_en),
        .res_idx  (wr_idx),
        .res_data (wr_data),
        .mv_we    (mv_near_we),
        .mv_idx   (mv_near_idx),
        .mv_data  (mv_near_data)
    );

    // Far write port: load return first, sequencer only when the port is free.
    vrf2_far_bank #(.DW(DW), .DEPTH(FAR_REGS)) u_far (
        .clk   (clk),
        .rst   (rst),
        .re    (far_re),
        .ridx  (far_ridx),
        .rdata (far_rdata),
        .we    (ld_en | mv_far_we),
        .widx  (ld_en ? ld_idx  : mv_far_idx),
        .wdata (ld_en ? ld_data : mv_far_data)
    );

    vrf2_move_seq #(.DW(DW), .NIW(NIW), .FIW(FIW)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (mv_valid),
        .cmd_dir       (mv_dir),
        .cmd_src       (mv_src),
        .cmd_dst       (mv_dst),
        .ld_busy       (ld_en),
        .near_src_data (near_rdata[2]),
        .far_rd_data   (far_rdata),
        .cmd_ready     (mv_ready),
        .cmd_done      (mv_done),
        .far_re        (far_re),
        .far_ridx      (far_ridx),
        .far_we        (mv_far_we),
        .far_widx      (mv_far_idx),
        .far_wdata     (mv_far_data),
        .near_we       (mv_near_we),
        .near_widx     (mv_near_idx),
        .near_wdata    (mv_near_data),
        .pend_near     (pend_near),
        .pend_idx      (pend_idx)
    );

    assign rd_stall = rd_en && pend_near &&
                      idx_hit2(16'(rd_a_idx), 16'(rd_b_idx), 16'(pend_idx));
endmodule

// File: rtl/vreg_two_level_chk.sv
module vreg_two_level_chk (
    input logic clk,
    input logic rst,
    input logic mv_valid,
    input logic mv_ready,
    input logic mv_done,
    input logic rd_stall,
    input logic ld_en,
    input logic mv_far_we
);
    // R3: completion is a single-cycle pulse.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        mv_done |=> !mv_done);

    // R3/R4: completion is only reported once the sequencer is idle again.
    p_done_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
        mv_done |-> mv_ready);

    // R8: an accepted command makes the sequencer busy on the next cycle.
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && mv_ready) |=> !mv_ready);

    // R7: a stall needs a move in flight.
    p_stall_needs_move_r7: assert property (@(posedge clk) disable iff (rst)
        rd_stall |-> !mv_ready);

    // R6: the far write port never takes both writers at once.
    p_far_port_single_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_en, mv_far_we}));
endmodule

bind vreg_two_level vreg_two_level_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mv_valid  (mv_valid),
    .mv_ready  (mv_ready),
    .mv_done   (mv_done),
    .rd_stall  (rd_stall),
    .ld_en     (ld_en),
    .mv_far_we (mv_far_we)
);

// File: tb/vreg_two_level_test.sv
`timescale 1ns/1ps
module vreg_two_level_test;
    localparam int DW = 64;
    localparam int NR = 16;
    localparam int FR = 80;

    logic          clk = 0;
    logic          rst = 1;
    logic          rd_en = 0;
    logic [3:0]    rd_a_idx = 0, rd_b_idx = 0;
    logic [DW-1:0] rd_a_data, rd_b_data;
    logic          rd_stall;
    logic          wr_en = 0;
    logic [3:0]    wr_idx = 0;
    logic [DW-1:0] wr_data = 0;
    logic          mv_valid = 0, mv_dir = 0;
    logic [6:0]    mv_src = 0, mv_dst = 0;
    logic          mv_ready, mv_done;
    logic          ld_en = 0;
    logic [6:0]    ld_idx = 0;
    logic [DW-1:0] ld_data = 0;

    int n_checks = 0;
    int n_fail   = 0;
    bit checking = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vreg_two_level uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .rd_stall(rd_stall),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mv_valid(mv_valid), .mv_dir(mv_dir), .mv_src(mv_src), .mv_dst(mv_dst),
        .mv_ready(mv_ready), .mv_done(mv_done),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data)
    );

    // ---------------- behavioural reference ----------------
    logic [DW-1:0] m_near [NR];
    logic [DW-1:0] m_far  [FR];
    int            m_phase;      // 0 idle, 1 latency, 2 landing
    logic          m_dir;
    logic [6:0]    m_src, m_dst;
    logic [DW-1:0] m_hold, m_xfer;
    logic          m_done;
    logic          nx_done;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NR; i++) m_near[i] = '0;
            for (int i = 0; i < FR; i++) m_far[i] = '0;
            m_phase = 0; m_done = 0; m_dir = 0; m_src = 0; m_dst = 0;
            m_hold = '0; m_xfer = '0;
        end else begin
            nx_done = 0;
            if (m_phase == 0) begin
                if (mv_valid) begin
                    m_dir = mv_dir; m_src = mv_src; m_dst = mv_dst;
                    m_hold = m_near[mv_src[3:0]];
                    m_phase = 1;
                end
            end else if (m_phase == 1) begin
                if (m_dir) m_xfer = (m_src < FR) ? m_far[m_src] : '0;
                m_phase = 2;
            end else begin
                if (m_dir) begin
                    m_near[m_dst[3:0]] = m_xfer;
                    m_phase = 0; nx_done = 1;
                end else if (!ld_en) begin
                    if (m_dst < FR) m_far[m_dst] = m_hold;
                    m_phase = 0; nx_done = 1;
                end
            end
            if (wr_en) m_near[wr_idx] = wr_data;
            if (ld_en && ld_idx < FR) m_far[ld_idx] = ld_data;
            m_done = nx_done;
        end
    end

    task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the clock edge.
    logic exp_stall;
    always @(negedge clk) begin
        #1;
        if (!rst && checking && !finished) begin
            exp_stall = rd_en && (m_phase != 0) && m_dir &&
                        (rd_a_idx == m_dst[3:0] || rd_b_idx == m_dst[3:0]);
            chk(DW'(rd_stall), DW'(exp_stall), "R7 stall");
            chk(DW'(mv_ready), DW'(m_phase == 0), "R8 ready");
            chk(DW'(mv_done), DW'(m_done), "R3 done pulse");
            if (!exp_stall) begin
                chk(rd_a_data, m_near[rd_a_idx], "R2 port A data");
                chk(rd_b_data, m_near[rd_b_idx], "R2 port B data");
            end
        end
    end

    function automatic logic [DW-1:0] pat(input int a, input int b);
        return {32'(a) ^ 32'hC0DE_0000, 32'(b) * 32'h0001_0003};
    endfunction

    task automatic quiet();
        @(negedge clk);
        rd_en = 0; wr_en = 0; mv_valid = 0; ld_en = 0;
    endtask

    task automatic read_near(input int idx, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        rd_a_idx = 4'(idx); rd_b_idx = 4'(idx);
        #1;
        chk(rd_a_data, exp, tag);
    endtask

    // Issues a move and returns the number of cycles until mv_done is seen.
    task automatic do_move(input logic dir, input int src, input int dst, output int lat);
        @(negedge clk);
        while (!mv_ready) @(negedge clk);
        mv_valid = 1; mv_dir = dir; mv_src = 7'(src); mv_dst = 7'(dst);
        lat = 0;
        @(negedge clk);
        mv_valid = 0;
        lat = 1;
        while (!mv_done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog R3 got=hung exp=complete");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [DW-1:0] v6;
        repeat (3) @(negedge clk);
        rst = 0;
        checking = 1;

        // R1: reset state
        @(negedge clk); #1;
        chk(DW'(mv_ready), 1, "R1 ready after reset");
        chk(DW'(mv_done), 0, "R1 done after reset");
        for (int i = 0; i < NR; i++) read_near(i, '0, "R1 near cleared");

        // R2: result writes
        for (int i = 0; i < NR; i++) begin
            @(negedge clk); wr_en = 1; wr_idx = 4'(i); wr_data = pat(i, 1);
        end
        quiet();
        for (int i = 0; i < NR; i++) read_near(i, pat(i, 1), "R2 result write");

        // R1: far tier cleared, seen through a move into near 15
        do_move(1, 79, 15, lat);
        read_near(15, '0, "R1 far cleared");

        // R5: loads fill far tier, near untouched
        for (int i = 0; i < FR; i++) begin
            @(negedge clk); ld_en = 1; ld_idx = 7'(i); ld_data = pat(i, 7);
        end
        quiet();
        read_near(4, pat(4, 1), "R5 near unaffected by loads");

        // R3 + R7: far to near with stall observation
        @(negedge clk);
        mv_valid = 1; mv_dir = 1; mv_src = 7'd20; mv_dst = 7'd3;
        @(negedge clk);
        mv_valid = 0; rd_en = 1; rd_a_idx = 3; rd_b_idx = 0; #1;
        chk(DW'(rd_stall), 1, "R7 stall on port A");
        @(negedge clk);
        rd_a_idx = 1; rd_b_idx = 3; #1;
        chk(DW'(rd_stall), 1, "R7 stall on port B");
        @(negedge clk); #1;
        chk(DW'(mv_done), 1, "R3 done three cycles after issue");
        chk(DW'(rd_stall), 0, "R7 stall released");
        chk(rd_b_data, pat(20, 7), "R3 far value landed");
        quiet();

        // R4: near to far, then back
        do_move(0, 5, 70, lat);
        chk(DW'(lat), 3, "R4 near-to-far latency");
        read_near(5, pat(5, 1), "R4 source kept");
        do_move(1, 70, 9, lat);
        read_near(9, pat(5, 1), "R4 value reached far tier");

        // R6: load holds the move's far write
        v6 = pat(6, 1);
        @(negedge clk);
        while (!mv_ready) @(negedge clk);
        mv_valid = 1; mv_dir = 0; mv_src = 7'd6; mv_dst = 7'd40;
        @(negedge clk);
        mv_valid = 0; ld_en = 1; ld_idx = 7'd40; ld_data = pat(99, 99);
        @(negedge clk); #1;
        chk(DW'(mv_done), 0, "R6 not done while load owns port");
        @(negedge clk); #1;
        chk(DW'(mv_done), 0, "R6 still held");
        @(negedge clk);
        ld_en = 0;
        @(negedge clk); #1;
        chk(DW'(mv_done), 1, "R6 done after load releases port");
        do_move(1, 40, 12, lat);
        read_near(12, v6, "R6 moved value overwrote load");

        // R9: result write coincides with landing move
        @(negedge clk);
        while (!mv_ready) @(negedge clk);
        mv_valid = 1; mv_dir = 1; mv_src = 7'd30; mv_dst = 7'd2;
        @(negedge clk);
        mv_valid = 0;
        @(negedge clk);
        wr_en = 1; wr_idx = 2; wr_data = pat(123, 4);
        @(negedge clk);
        wr_en = 0;
        read_near(2, pat(123, 4), "R9 result write wins");

        // R8: command during busy ignored
        @(negedge clk);
        while (!mv_ready) @(negedge clk);
        mv_valid = 1; mv_dir = 1; mv_src = 7'd21; mv_dst = 7'd4;
        @(negedge clk);
        mv_src = 7'd22; mv_dst = 7'd11;
        @(negedge clk);
        mv_valid = 0;
        repeat (4) @(negedge clk);
        #1;
        chk(DW'(mv_ready), 1, "R8 idle after single move");
        read_near(11, pat(11, 1), "R8 busy-time command ignored");
        read_near(4, pat(21, 7), "R8 accepted move landed");

        // Mixed random traffic, compared every cycle
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            rd_en    = 1;
            rd_a_idx = 4'($urandom_range(0, NR - 1));
            rd_b_idx = 4'($urandom_range(0, NR - 1));
            wr_en    = ($urandom_range(0, 1) == 1);
            wr_idx   = 4'($urandom_range(0, NR - 1));
            wr_data  = {$urandom, $urandom};
            mv_valid = ($urandom_range(0, 3) == 0);
            mv_dir   = 1'($urandom_range(0, 1));
            mv_src   = 7'($urandom_range(0, FR - 1));
            mv_dst   = 7'($urandom_range(0, FR - 1));
            ld_en    = ($urandom_range(0, 2) == 0);
            ld_idx   = 7'($urandom_range(0, FR - 1));
            ld_data  = {$urandom, $urandom};
        end
        quiet();
        repeat (6) @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule